// File: doc/BRIEF.md
# Four-Byte Page Write Buffer

This block sits between the serial command decoder and the on-chip byte array of a small serial storage device. When a write command begins, the decoder hands it the 9-bit starting address. Each later complete data byte arrives as a one-cycle strobe and is placed in one of four page entries. The entry is chosen by the two low address bits, which advance after every byte and wrap inside the page. A byte that lands on an entry already filled in this command replaces the earlier byte.

The command ends when chip select goes high. The decoder reports that event together with a flag. The flag is set only if the rise fell in the clock-low window right after the last bit of a byte. The protection block supplies a grant. A clean, granted end with at least one buffered byte starts a timed programming cycle. When the timer expires, the block drives one strobe per filled entry toward the array. Any other end of command throws the buffer away. While the cycle runs, the block reports busy and ignores all command traffic. No stored byte changes before the cycle completes. No erase step is involved: each written byte simply replaces the old one.

Top module: `page_write_buffer`

## Requirements
- R1: During the strobe cycle, entry i (i = low two address bits) is presented on `wr_data[8*i+7:8*i]`. `wr_page` carries the upper seven address bits. Entries not written in the command read as zero. Outside the strobe cycle, `wr_data` and `wr_page` are zero.
- R2: After each accepted byte only the two low address bits advance, modulo 4. A fifth or later byte overwrites the entry written four bytes earlier.
- R3: `wr_page` equals bits 8..2 of the starting address, even when the low bits wrapped past the end of the page.
- R4: A `cs_rise` with `cs_on_boundary`=1, `grant`=1 and at least one buffered byte raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles.
- R5: `wr_strb` is non-zero only in the last busy cycle, for exactly one cycle, and there equals the set of entries written in the command (bit i for entry i).
- R6: A `cs_rise` with `cs_on_boundary`=0 starts no cycle and discards the buffered bytes.
- R7: A `cs_rise` with `grant`=0 starts no cycle and discards the buffered bytes.
- R8: A `cs_rise` with no byte received since the command began starts no cycle.
- R9: While `busy` is high, `cmd_start`, `byte_vld` and `cs_rise` have no effect.
- R10: `cmd_start` clears every buffered entry. A second `cmd_start` before `cs_rise` restarts the command at the new address.
- R11: `byte_vld` has no effect outside a command, and none in the cycle where `cs_rise` is high.
- R12: After reset `busy` is low and `wr_strb` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Write command begins; `start_addr` valid |
| start_addr | input | 9 | First byte address of the command |
| byte_vld | input | 1 | One complete data byte received |
| byte_data | input | 8 | The received byte |
| cs_rise | input | 1 | Chip select went high |
| cs_on_boundary | input | 1 | The rise came right after a byte's last bit |
| grant | input | 1 | Protection block permits this write |
| busy | output | 1 | Programming cycle in progress |
| wr_strb | output | 4 | Per-entry write strobe toward the array |
| wr_page | output | 7 | Upper address bits for the strobed entries |
| wr_data | output | 32 | Entry data, entry i on bits 8i+7..8i |

## Verification
The hardest states to reach from the ports are those where traffic arrives during a running cycle, and those where a new command starts in a lane other than 0 and then wraps. The stimulus covers the first with a full command (start, byte, chip-select rise) issued mid-cycle. It covers the second with an address of 0x1FE and with five bytes into one page. A behavioural model that tracks a remaining-cycle count predicts every output on every clock. A shadow array fed by the strobes confirms which bytes landed.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_PROG    = 2'd2
    } pwb_state_e;
endpackage

// File: rtl/page_lane_store.sv
module page_lane_store #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [LANE_W-1:0]       wr_lane,
    input  logic [DATA_W-1:0]       wr_byte,
    output logic [LANES-1:0]        vld,
    output logic [LANES*DATA_W-1:0] data
);
    typedef struct packed {
        logic [LANES-1:0]        vld;
        logic [LANES*DATA_W-1:0] data;
    } store_t;

    store_t st_d, st_q;
    logic [LANES-1:0] lane_hit;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign lane_hit[g] = wr && (wr_lane == LANE_W'(g));

            // R2
            lane_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.vld[g]) |-> $past(wr && !clr && wr_lane == LANE_W'(g)));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.vld  = '0;
            st_d.data = '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_hit[i]) begin
                    st_d.vld[i] = 1'b1;
                    st_d.data[i*DATA_W +: DATA_W] = wr_byte;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld  = st_q.vld;
    assign data = st_q.data;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CYCLES = 40,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)              cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == CNT_W'(1));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(CYCLES));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
    import pwb_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int PROG_CYCLES = 40,
    localparam int LANE_W = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - LANE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_start,
    input  logic [ADDR_W-1:0]            start_addr,
    input  logic                         byte_vld,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         cs_rise,
    input  logic                         cs_on_boundary,
    input  logic                         grant,
    output logic                         busy,
    output logic [PAGE_BYTES-1:0]        wr_strb,
    output logic [PAGE_W-1:0]            wr_page,
    output logic [PAGE_BYTES*DATA_W-1:0] wr_data
);
    typedef struct packed {
        pwb_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [LANE_W-1:0] ptr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                         buf_clr, buf_wr, tmr_start, tmr_done, commit;
    logic [PAGE_BYTES-1:0]        buf_vld;
    logic [PAGE_BYTES*DATA_W-1:0] buf_data;

    page_lane_store #(.LANES(PAGE_BYTES), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr      (buf_wr),
        .wr_lane (ctl_q.ptr),
        .wr_byte (byte_data),
        .vld     (buf_vld),
        .data    (buf_data)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        tmr_start = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_start) begin
                    ctl_d.state = ST_COLLECT;
                    ctl_d.page  = start_addr[ADDR_W-1:LANE_W];
                    ctl_d.ptr   = start_addr[LANE_W-1:0];
                    buf_clr     = 1'b1;
                end
            end
            ST_COLLECT: begin
                if (cs_rise) begin
                    if (cs_on_boundary && grant && (buf_vld != '0)) begin
                        ctl_d.state = ST_PROG;
                        tmr_start   = 1'b1;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        buf_clr     = 1'b1;
                    end
                end else if (cmd_start) begin
                    ctl_d.page = start_addr[ADDR_W-1:LANE_W];
                    ctl_d.ptr  = start_addr[LANE_W-1:0];
                    buf_clr    = 1'b1;
                end else if (byte_vld) begin
                    buf_wr    = 1'b1;
                    ctl_d.ptr = ctl_q.ptr + LANE_W'(1);
                end
            end
            ST_PROG: begin
                if (tmr_done) begin
                    ctl_d.state = ST_IDLE;
                    buf_clr     = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, page: '0, ptr: '0};
        else        ctl_q <= ctl_d;
    end

    assign busy    = (ctl_q.state == ST_PROG);
    assign commit  = busy && tmr_done;
    assign wr_strb = commit ? buf_vld  : '0;
    assign wr_data = commit ? buf_data : '0;
    assign wr_page = commit ? ctl_q.page : '0;

    // R5
    strb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strb != '0) |-> busy);
    // R5
    strb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strb != '0) |=> (wr_strb == '0) && !busy);
    // R4
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_on_boundary && grant));
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> busy && $stable(ctl_q.page) && $stable(buf_vld));
    // R12
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> !busy && (wr_strb == '0));
endmodule

// File: tb/page_write_buffer_tb.sv
`timescale 1ns/1ps
module page_write_buffer_tb;
    localparam int P = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 1'b0;
    logic [8:0] start_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cs_rise = 1'b0;
    logic       cs_on_boundary = 1'b0;
    logic       grant = 1'b0;
    logic       busy;
    logic [3:0] wr_strb;
    logic [6:0] wr_page;
    logic [31:0] wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    page_write_buffer #(.PROG_CYCLES(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_on_boundary(cs_on_boundary), .grant(grant),
        .busy(busy), .wr_strb(wr_strb), .wr_page(wr_page), .wr_data(wr_data)
    );

    // reference model
    bit         m_coll, m_prog;
    int         m_left;
    logic [6:0] m_page;
    int         m_ptr;
    logic [3:0] m_vld;
    logic [7:0] m_dat [4];
    logic [7:0] mem [512];

    task automatic m_clear();
        m_vld = '0;
        for (int i = 0; i < 4; i++) m_dat[i] = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_coll = 0; m_prog = 0; m_left = 0; m_page = '0; m_ptr = 0; m_clear();
        end else if (m_prog) begin
            if (m_left == 1) begin m_prog = 0; m_coll = 0; m_clear(); end
            else m_left--;
        end else if (m_coll) begin
            if (cs_rise) begin
                if (cs_on_boundary && grant && m_vld != 0) begin m_prog = 1; m_left = P; end
                else begin m_coll = 0; m_clear(); end
            end else if (cmd_start) begin
                m_page = start_addr[8:2]; m_ptr = int'(start_addr[1:0]); m_clear();
            end else if (byte_vld) begin
                m_dat[m_ptr] = byte_data; m_vld[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 4;
            end
        end else if (cmd_start) begin
            m_coll = 1; m_page = start_addr[8:2]; m_ptr = int'(start_addr[1:0]); m_clear();
        end
    end

    // shadow array fed by the design's strobes
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (wr_strb[i]) mem[{wr_page, 2'(i)}] = wr_data[8*i +: 8];
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic       eb;
            logic [3:0] es;
            logic [31:0] ed;
            logic [6:0] ep;
            eb = m_prog;
            es = (m_prog && m_left == 1) ? m_vld : 4'h0;
            ed = (es != 0) ? {m_dat[3], m_dat[2], m_dat[1], m_dat[0]} : 32'h0;
            ep = (es != 0) ? m_page : 7'h0;
            check(busy == eb, "R4", "busy", 32'(busy), 32'(eb));
            check(wr_strb == es, "R5", "wr_strb", 32'(wr_strb), 32'(es));
            check(wr_data == ed, "R1", "wr_data", wr_data, ed);
            check(wr_page == ep, "R3", "wr_page", 32'(wr_page), 32'(ep));
        end
    end

    task automatic drive(bit cs_, logic [8:0] a, bit bv, logic [7:0] bd, bit cr, bit cb, bit gr);
        @(negedge clk);
        #1;
        cmd_start = cs_; start_addr = a; byte_vld = bv; byte_data = bd;
        cs_rise = cr; cs_on_boundary = cb; grant = gr;
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, '0, 0, '0, 0, 0, 0);
    endtask
    task automatic start_cmd(logic [8:0] a);  drive(1, a, 0, '0, 0, 0, 0); endtask
    task automatic send(logic [7:0] d);        drive(0, '0, 1, d, 0, 0, 0); endtask
    task automatic end_cmd(bit cb, bit gr);    drive(0, '0, 0, '0, 1, cb, gr); endtask
    task automatic chk_mem(int a, logic [7:0] e, string req);
        check(mem[a] == e, req, $sformatf("mem[%0h]", a), 32'(mem[a]), 32'(e));
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(busy == 1'b0, "R12", "busy in reset", 32'(busy), 0);
        check(wr_strb == 4'h0, "R12", "wr_strb in reset", 32'(wr_strb), 0);
        rst_n = 1'b1;
        idle(2);

        // R1: full aligned page
        start_cmd(9'h040); send(8'hA0); send(8'hA1); send(8'hA2); send(8'hA3);
        end_cmd(1, 1);
        idle(1);
        check(busy == 1'b1, "R4", "busy after commit", 32'(busy), 1);
        idle(P + 2);
        chk_mem(9'h040, 8'hA0, "R1"); chk_mem(9'h043, 8'hA3, "R1");

        // R2/R3: start at 0x1FE, wrap inside the page
        start_cmd(9'h1FE); send(8'h11); send(8'h22); send(8'h33);
        end_cmd(1, 1); idle(P + 2);
        chk_mem(9'h1FE, 8'h11, "R3"); chk_mem(9'h1FF, 8'h22, "R3");
        chk_mem(9'h1FC, 8'h33, "R2"); chk_mem(9'h000, 8'h00, "R3");

        // R2: five bytes, fifth overwrites the first
        start_cmd(9'h010);
        send(8'h51); send(8'h52); send(8'h53); send(8'h54); send(8'h55);
        end_cmd(1, 1); idle(P + 2);
        chk_mem(9'h010, 8'h55, "R2"); chk_mem(9'h011, 8'h52, "R2");

        // R5: single byte, only its strobe
        start_cmd(9'h0A1); send(8'h77); end_cmd(1, 1); idle(P + 2);
        chk_mem(9'h0A1, 8'h77, "R5"); chk_mem(9'h0A0, 8'h00, "R5");

        // R6: rise off the byte boundary discards
        start_cmd(9'h030); send(8'hC0); send(8'hC1); end_cmd(0, 1); idle(2);
        check(busy == 1'b0, "R6", "busy after bad boundary", 32'(busy), 0);
        start_cmd(9'h030); send(8'hD0); end_cmd(1, 1); idle(P + 2);
        chk_mem(9'h030, 8'hD0, "R6"); chk_mem(9'h031, 8'h00, "R6");

        // R7: no grant
        start_cmd(9'h070); send(8'hE0); end_cmd(1, 0); idle(P + 2);
        check(busy == 1'b0, "R7", "busy without grant", 32'(busy), 0);
        chk_mem(9'h070, 8'h00, "R7");

        // R8: no data byte
        start_cmd(9'h080); end_cmd(1, 1); idle(2);
        check(busy == 1'b0, "R8", "busy with no byte", 32'(busy), 0);

        // R9: traffic while busy is ignored
        start_cmd(9'h090); send(8'h91); end_cmd(1, 1);
        idle(2);
        start_cmd(9'h0B0); send(8'hB1); end_cmd(1, 1);
        idle(P + 2);
        chk_mem(9'h090, 8'h91, "R9"); chk_mem(9'h0B0, 8'h00, "R9");
        check(busy == 1'b0, "R9", "busy after ignored traffic", 32'(busy), 0);

        // R10: restart clears earlier bytes
        start_cmd(9'h050); send(8'h5A); send(8'h5B);
        start_cmd(9'h060); send(8'h6A); end_cmd(1, 1); idle(P + 2);
        chk_mem(9'h050, 8'h00, "R10"); chk_mem(9'h060, 8'h6A, "R10");
        chk_mem(9'h061, 8'h00, "R10");

        // R11: stray bytes outside a command and on the rise cycle
        send(8'hEE);
        start_cmd(9'h0C0); send(8'hC7);
        drive(0, '0, 1, 8'hEF, 1, 1, 1);
        idle(P + 2);
        chk_mem(9'h0C0, 8'hC7, "R11"); chk_mem(9'h0C1, 8'h00, "R11");

        idle(2);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule